// File: doc/BRIEF.md
# Two-Port Word Memory with Collision Flagging

This block wraps a single-clock memory that two independent ports, named left and right, can access in every cycle. Each port drives its own enable, write strobe, per-lane write mask, word address and write data. It receives a read word and a one-cycle BUSY pulse. The data word is made of 9-bit lanes. A write changes only the lanes whose mask bit is set.

When both ports touch the same word in the same cycle and at least one of them writes, the block decides which port ends up with unreliable data. It flags only that port. The word address of the first such clash is latched together with a valid bit. Either port can read this record back through its normal read path by raising a per-port readback command. A clear input empties the record and arms it for the next clash. A static strap selects the read latency: pipelined mode adds an output register, and flow-through mode has one cycle less.

Top module: `dual_port_conflict_ram`

## Requirements
- R1: A write updates lane i (data bits [9i+8:9i]) only when bit i of that port's lane mask is 1. All other lanes of the word keep their contents.
- R2: With `pipe_mode` low, read data appears on the port output in the cycle after the clock edge that samples the request. With `pipe_mode` high, it appears one cycle later.
- R3: If one port writes a word and the other port reads the same word in the same cycle, the reader is flagged BUSY and returns the contents from before the write. The write still takes effect.
- R4: If both ports write the same word in the same cycle, the left port's data is stored, the right port's write is dropped, and the right port is flagged BUSY.
- R5: Two reads of the same word in one cycle are not a clash. Neither port is flagged, and both return the stored word.
- R6: BUSY is a single-cycle pulse on the flagged port only. It appears with the same latency as read data would for a request in that cycle. It is never high on both ports in the same cycle.
- R7: The first clash after reset or clear latches its word address and sets the valid bit. Later clashes leave the latched address unchanged.
- R8: A port whose readback command is high performs no memory access in that cycle. It returns a word with the valid bit at bit position ADDR_W, the latched address in bits [ADDR_W-1:0] and zeros above, with the same latency as a read. The word reflects the record as it stood before that cycle's edge.
- R9: `clr_busy_addr` empties the record (valid 0, address 0). It takes priority over a clash in the same cycle, which is then not recorded.
- R10: A port whose enable is low (and readback low) writes nothing, reads nothing and cannot take part in a clash.
- R11: After reset both read outputs are zero, both BUSY outputs are low and the record is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | Latency strap: 1 pipelined, 0 flow-through |
| clr_busy_addr | input | 1 | Empties the clash record |
| lt_en | input | 1 | Left port access enable |
| lt_we | input | 1 | Left port write (1) or read (0) |
| lt_be | input | LANES | Left port lane write mask |
| lt_addr | input | ADDR_W | Left port word address |
| lt_wdata | input | LANES*LANE_W | Left port write data |
| lt_bar_rd | input | 1 | Left port clash record readback command |
| lt_rdata | output | LANES*LANE_W | Left port read data |
| lt_busy | output | 1 | Left port clash flag |
| rt_en | input | 1 | Right port access enable |
| rt_we | input | 1 | Right port write (1) or read (0) |
| rt_be | input | LANES | Right port lane write mask |
| rt_addr | input | ADDR_W | Right port word address |
| rt_wdata | input | LANES*LANE_W | Right port write data |
| rt_bar_rd | input | 1 | Right port clash record readback command |
| rt_rdata | output | LANES*LANE_W | Right port read data |
| rt_busy | output | 1 | Right port clash flag |

## Verification
Same-word traffic is driven in each orientation that matters. A left write against a right read, and a right write against a left read, show whether the flag lands on the reader and whether the old data is returned. Two writes show left priority and the dropped right write. Two reads show that shared reads raise no flag. Disjoint writes, partial lane masks and a disabled port separate lane merging from collision handling. Readback before and after clear, a clear coinciding with a clash, and repeated clashes show first-capture and the clear priority. Every pattern is run under both latency settings.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  localparam int PORTS = 2;

  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_WW    = 2'd1,
    CK_AW_BR = 2'd2,
    CK_BW_AR = 2'd3
  } coll_kind_t;

  // Classify a same-word clash given which side writes.
  function automatic coll_kind_t classify(input logic hit, input logic a_we, input logic b_we);
    if (!hit) return CK_NONE;
    if (a_we && b_we) return CK_WW;
    if (a_we) return CK_AW_BR;
    return CK_BW_AR;
  endfunction

endpackage

// File: rtl/dpc_collide.sv
module dpc_collide
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              a_act,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_act,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  output coll_kind_t        kind,
  output logic              hit,
  output logic [PORTS-1:0]  flag,
  output logic              b_wr_keep
);

  logic same_word;

  assign same_word = (a_addr == b_addr);
  assign hit       = a_act && b_act && same_word && (a_we || b_we);
  assign kind      = classify(hit, a_we, b_we);

  // index 0 = left, 1 = right
  assign flag[0]   = (kind == CK_BW_AR);
  assign flag[1]   = (kind == CK_WW) || (kind == CK_AW_BR);
  assign b_wr_keep = (kind != CK_WW);

endmodule

// File: rtl/dpc_capture.sv
module dpc_capture #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  output logic              valid,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      addr_q <= '0;
    end else if (clr) begin
      valid  <= 1'b0;
      addr_q <= '0;
    end else if (hit && !valid) begin
      valid  <= 1'b1;
      addr_q <= hit_addr;
    end
  end

endmodule

// File: rtl/dpc_storage.sv
module dpc_storage
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [PORTS-1:0]                     we,
  input  logic [PORTS-1:0]                     re,
  input  logic [PORTS-1:0][LANES-1:0]          be,
  input  logic [PORTS-1:0][ADDR_W-1:0]         addr,
  input  logic [PORTS-1:0][LANES*LANE_W-1:0]   wdata,
  output logic [PORTS-1:0][LANES*LANE_W-1:0]   q
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [DATA_W-1:0] merge_lanes(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [LANES-1:0]  mask
  );
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int l = 0; l < LANES; l++) begin
      if (mask[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (we[p]) mem[addr[p]] <= merge_lanes(mem[addr[p]], wdata[p], be[p]);
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    logic [DATA_W-1:0] rq;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rq <= '0;
      else if (re[p]) rq <= mem[addr[p]];
    end
    assign q[p] = rq;
  end

endmodule

// File: rtl/dpc_read_pipe.sv
module dpc_read_pipe #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              rd_req,
  input  logic              bar_req,
  input  logic [DATA_W-1:0] bar_word,
  input  logic [DATA_W-1:0] mem_q,
  input  logic              flag,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);

  logic              s1_vld, s1_bar, s1_busy, s2_busy;
  logic [DATA_W-1:0] s1_bword, s1_data, s2_data;
  logic              any_req;

  assign any_req = rd_req || bar_req;
  assign s1_data = s1_bar ? s1_bword : mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_bar   <= 1'b0;
      s1_bword <= '0;
      s1_busy  <= 1'b0;
    end else begin
      s1_vld  <= any_req;
      s1_busy <= flag;
      if (any_req) s1_bar   <= bar_req;
      if (bar_req) s1_bword <= bar_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_data <= '0;
      s2_busy <= 1'b0;
    end else begin
      s2_busy <= s1_busy;
      if (s1_vld) s2_data <= s1_data;
    end
  end

  assign rdata = pipe_mode ? s2_data : s1_data;
  assign busy  = pipe_mode ? s2_busy : s1_busy;

endmodule

// File: rtl/dual_port_conflict_ram.sv
module dual_port_conflict_ram
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pipe_mode,
  input  logic                     clr_busy_addr,
  input  logic                     lt_en,
  input  logic                     lt_we,
  input  logic [LANES-1:0]         lt_be,
  input  logic [ADDR_W-1:0]        lt_addr,
  input  logic [LANES*LANE_W-1:0]  lt_wdata,
  input  logic                     lt_bar_rd,
  output logic [LANES*LANE_W-1:0]  lt_rdata,
  output logic                     lt_busy,
  input  logic                     rt_en,
  input  logic                     rt_we,
  input  logic [LANES-1:0]         rt_be,
  input  logic [ADDR_W-1:0]        rt_addr,
  input  logic [LANES*LANE_W-1:0]  rt_wdata,
  input  logic                     rt_bar_rd,
  output logic [LANES*LANE_W-1:0]  rt_rdata,
  output logic                     rt_busy
);

  localparam int DATA_W = LANES * LANE_W;

  // Named internal events, observed by the bound checker.
  logic                            lt_act, rt_act;
  coll_kind_t                      coll_kind;
  logic                            coll_hit;
  logic [PORTS-1:0]                coll_flag;
  logic                            rt_wr_keep;
  logic                            cap_valid;
  logic [ADDR_W-1:0]               cap_addr;
  logic [DATA_W-1:0]               bar_word;

  logic [PORTS-1:0]                p_we, p_re, p_bar;
  logic [PORTS-1:0][LANES-1:0]     p_be;
  logic [PORTS-1:0][ADDR_W-1:0]    p_addr;
  logic [PORTS-1:0][DATA_W-1:0]    p_wdata, p_q, p_rdata;
  logic [PORTS-1:0]                p_busy;

  assign lt_act = lt_en && !lt_bar_rd;
  assign rt_act = rt_en && !rt_bar_rd;

  dpc_collide #(.ADDR_W(ADDR_W)) u_collide (
    .a_act     (lt_act),
    .a_we      (lt_we),
    .a_addr    (lt_addr),
    .b_act     (rt_act),
    .b_we      (rt_we),
    .b_addr    (rt_addr),
    .kind      (coll_kind),
    .hit       (coll_hit),
    .flag      (coll_flag),
    .b_wr_keep (rt_wr_keep)
  );

  dpc_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_busy_addr),
    .hit      (coll_hit),
    .hit_addr (lt_addr),
    .valid    (cap_valid),
    .addr_q   (cap_addr)
  );

  assign bar_word = DATA_W'({cap_valid, cap_addr});

  assign p_we[0]    = lt_act && lt_we;
  assign p_we[1]    = rt_act && rt_we && rt_wr_keep;
  assign p_re[0]    = lt_act && !lt_we;
  assign p_re[1]    = rt_act && !rt_we;
  assign p_bar[0]   = lt_bar_rd;
  assign p_bar[1]   = rt_bar_rd;
  assign p_be[0]    = lt_be;
  assign p_be[1]    = rt_be;
  assign p_addr[0]  = lt_addr;
  assign p_addr[1]  = rt_addr;
  assign p_wdata[0] = lt_wdata;
  assign p_wdata[1] = rt_wdata;

  dpc_storage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_storage (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (p_we),
    .re    (p_re),
    .be    (p_be),
    .addr  (p_addr),
    .wdata (p_wdata),
    .q     (p_q)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    dpc_read_pipe #(.DATA_W(DATA_W)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .pipe_mode (pipe_mode),
      .rd_req    (p_re[p]),
      .bar_req   (p_bar[p]),
      .bar_word  (bar_word),
      .mem_q     (p_q[p]),
      .flag      (coll_flag[p]),
      .rdata     (p_rdata[p]),
      .busy      (p_busy[p])
    );
  end

  assign lt_rdata = p_rdata[0];
  assign rt_rdata = p_rdata[1];
  assign lt_busy  = p_busy[0];
  assign rt_busy  = p_busy[1];

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              clr,
  input logic              lt_busy,
  input logic              rt_busy,
  input logic [ADDR_W-1:0] lt_addr,
  input coll_kind_t        coll_kind,
  input logic              coll_hit,
  input logic              cap_valid,
  input logic [ADDR_W-1:0] cap_addr
);

  AST_BUSY_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lt_busy && rt_busy)); // R6

  AST_WW_FLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(coll_kind == CK_WW)) |-> (rt_busy && !lt_busy)); // R4

  AST_WW_PIPE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(coll_kind == CK_WW, 2)) |-> (rt_busy && !lt_busy)); // R4

  AST_READER_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(coll_kind == CK_BW_AR)) |-> (lt_busy && !rt_busy)); // R3

  AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(coll_hit && !cap_valid && !clr) |-> (cap_valid && cap_addr == $past(lt_addr))); // R7

  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_valid && !clr) |-> (cap_valid && $stable(cap_addr))); // R7

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (!cap_valid && cap_addr == '0)); // R9

endmodule

bind dual_port_conflict_ram dpc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pipe_mode (pipe_mode),
  .clr       (clr_busy_addr),
  .lt_busy   (lt_busy),
  .rt_busy   (rt_busy),
  .lt_addr   (lt_addr),
  .coll_kind (coll_kind),
  .coll_hit  (coll_hit),
  .cap_valid (cap_valid),
  .cap_addr  (cap_addr)
);

// File: tb/dual_port_conflict_ram_test.sv
module dual_port_conflict_ram_test;

  localparam int PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  typedef struct {
    int            due;
    bit            has_data;
    logic [DW-1:0] data;
    bit            busy;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pipe_mode = 1'b0;
  logic          clr_busy_addr = 1'b0;
  logic          lt_en = 0, lt_we = 0, lt_bar_rd = 0;
  logic [NL-1:0] lt_be = '0;
  logic [AW-1:0] lt_addr = '0;
  logic [DW-1:0] lt_wdata = '0;
  logic          rt_en = 0, rt_we = 0, rt_bar_rd = 0;
  logic [NL-1:0] rt_be = '0;
  logic [AW-1:0] rt_addr = '0;
  logic [DW-1:0] rt_wdata = '0;
  logic [DW-1:0] lt_rdata, rt_rdata;
  logic          lt_busy, rt_busy;

  dual_port_conflict_ram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .clr_busy_addr(clr_busy_addr),
    .lt_en(lt_en), .lt_we(lt_we), .lt_be(lt_be), .lt_addr(lt_addr), .lt_wdata(lt_wdata),
    .lt_bar_rd(lt_bar_rd), .lt_rdata(lt_rdata), .lt_busy(lt_busy),
    .rt_en(rt_en), .rt_we(rt_we), .rt_be(rt_be), .rt_addr(rt_addr), .rt_wdata(rt_wdata),
    .rt_bar_rd(rt_bar_rd), .rt_rdata(rt_rdata), .rt_busy(rt_busy)
  );

  always #(PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail = 0;
  bit mon_on = 0;

  logic [DW-1:0] shadow [1 << AW];
  bit            rec_valid;
  logic [AW-1:0] rec_addr;
  item_t         q_lt[$];
  item_t         q_rt[$];

  task automatic check_val(input bit ok, input string tag, input string what,
                           input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  // Lane merge restated: walk the word bit by bit, picking by lane index.
  function automatic logic [DW-1:0] apply_mask(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [NL-1:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < DW; b++) r[b] = m[b / LW] ? new_w[b] : old_w[b];
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(input int k);
    logic [15:0] s;
    s = 16'(k * 40503 + 17);
    return {s[3:0], s, ~s};
  endfunction

  // Driver: issue one cycle on both ports, push expected results, update model.
  task automatic step(
    input bit ae, input bit awe, input bit abar, input logic [NL-1:0] abe,
    input logic [AW-1:0] aad, input logic [DW-1:0] awd,
    input bit be_, input bit bwe, input bit bbar, input logic [NL-1:0] bbe,
    input logic [AW-1:0] bad, input logic [DW-1:0] bwd,
    input bit clr, input string tag);
    bit a_act, b_act, hit, a_flag, b_flag;
    int due;
    logic [DW-1:0] recw;
    item_t it;
    @(posedge clk); #1;
    lt_en = ae; lt_we = awe; lt_bar_rd = abar; lt_be = abe; lt_addr = aad; lt_wdata = awd;
    rt_en = be_; rt_we = bwe; rt_bar_rd = bbar; rt_be = bbe; rt_addr = bad; rt_wdata = bwd;
    clr_busy_addr = clr;
    a_act  = ae && !abar;
    b_act  = be_ && !bbar;
    hit    = a_act && b_act && (aad == bad) && (awe || bwe);
    a_flag = hit && !awe;
    b_flag = hit && awe;
    due    = cyc + 1 + (pipe_mode ? 1 : 0);
    recw   = '0;
    recw[AW] = rec_valid;
    recw[AW-1:0] = rec_addr;
    if (abar) begin
      it = '{due, 1'b1, recw, 1'b0, tag}; q_lt.push_back(it);
    end else if (a_act && !awe) begin
      it = '{due, 1'b1, shadow[aad], a_flag, tag}; q_lt.push_back(it);
    end else if (a_flag) begin
      it = '{due, 1'b0, '0, 1'b1, tag}; q_lt.push_back(it);
    end
    if (bbar) begin
      it = '{due, 1'b1, recw, 1'b0, tag}; q_rt.push_back(it);
    end else if (b_act && !bwe) begin
      it = '{due, 1'b1, shadow[bad], b_flag, tag}; q_rt.push_back(it);
    end else if (b_flag) begin
      it = '{due, 1'b0, '0, 1'b1, tag}; q_rt.push_back(it);
    end
    if (a_act && awe) shadow[aad] = apply_mask(shadow[aad], awd, abe);
    if (b_act && bwe && !(hit && awe)) shadow[bad] = apply_mask(shadow[bad], bwd, bbe);
    if (clr) begin
      rec_valid = 0; rec_addr = '0;
    end else if (hit && !rec_valid) begin
      rec_valid = 1; rec_addr = aad;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0,0,0,'0,'0,'0, 0,0,0,'0,'0,'0, 0, "idle");
  endtask

  // Monitor: compare each port against the front of its queue.
  task automatic mon_port(ref item_t q[$], input logic [DW-1:0] rd, input logic bz,
                          input string side);
    item_t it;
    if (q.size() > 0 && q[0].due == cyc) begin
      it = q.pop_front();
      check_val(bz === it.busy, it.tag, {side, " busy"}, DW'(bz), DW'(it.busy));
      if (it.has_data) check_val(rd === it.data, it.tag, {side, " data"}, rd, it.data);
    end else begin
      check_val(bz === 1'b0, "R6", {side, " stray busy"}, DW'(bz), '0);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      mon_port(q_lt, lt_rdata, lt_busy, "left");
      mon_port(q_rt, rt_rdata, rt_busy, "right");
    end
  end

  task automatic do_reset(input bit mode);
    mon_on = 0;
    @(posedge clk); #1;
    rst_n = 0;
    pipe_mode = mode;
    lt_en = 0; rt_en = 0; lt_bar_rd = 0; rt_bar_rd = 0; clr_busy_addr = 0;
    q_lt.delete(); q_rt.delete();
    rec_valid = 0; rec_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check_val(lt_rdata === '0 && rt_rdata === '0, "R11", "rdata after reset",
              lt_rdata | rt_rdata, '0);
    check_val(lt_busy === 1'b0 && rt_busy === 1'b0, "R11", "busy after reset",
              DW'({lt_busy, rt_busy}), '0);
    mon_on = 1;
  endtask

  task automatic run_mode(input bit mode);
    int base;
    base = mode ? 100 : 0;
    do_reset(mode);
    // R11: record is empty after reset
    step(0,0,1,'0,'0,'0, 0,0,0,'0,'0,'0, 0, "R11 record empty");
    // Fill 0..15 with disjoint full-mask writes (R1)
    for (int i = 0; i < 8; i++)
      step(1,1,0,4'hF,AW'(2*i),pat(base+2*i), 1,1,0,4'hF,AW'(2*i+1),pat(base+2*i+1), 0, "R1 fill");
    step(1,1,0,4'h5,1,pat(base+50), 1,1,0,4'hA,2,pat(base+51), 0, "R1 lane mask");
    step(1,0,0,'0,1,'0, 1,0,0,'0,2,'0, 0, "R1 R2 read masked");
    step(1,0,0,'0,3,'0, 1,0,0,'0,4,'0, 0, "R2 back to back");
    step(1,0,0,'0,4,'0, 1,0,0,'0,3,'0, 0, "R2 back to back");
    step(1,0,0,'0,1,'0, 1,0,0,'0,1,'0, 0, "R5 shared read");
    step(1,1,0,4'hF,5,pat(base+60), 1,0,0,'0,5,'0, 0, "R3 left writes right reads");
    step(1,0,0,'0,5,'0, 1,0,0,'0,5,'0, 0, "R3 write landed");
    step(1,0,0,'0,6,'0, 1,1,0,4'h3,6,pat(base+61), 0, "R3 right writes left reads");
    step(1,1,0,4'hF,7,pat(base+62), 1,1,0,4'hF,7,pat(base+63), 0, "R4 both write");
    step(1,0,0,'0,7,'0, 1,0,0,'0,6,'0, 0, "R4 R3 read after");
    step(0,0,1,'0,'0,'0, 0,0,1,'0,'0,'0, 0, "R7 R8 first address kept");
    step(1,0,1,'0,5,'0, 1,1,0,4'hF,5,pat(base+64), 0, "R8 readback is no access");
    step(1,0,0,'0,5,'0, 0,0,1,'0,'0,'0, 0, "R8 R7 no new capture");
    step(0,0,0,'0,'0,'0, 0,0,0,'0,'0,'0, 1, "R9 clear");
    step(0,0,1,'0,'0,'0, 0,0,0,'0,'0,'0, 0, "R9 empty after clear");
    step(1,1,0,4'hF,9,pat(base+65), 1,0,0,'0,9,'0, 1, "R9 clear beats capture");
    step(0,0,1,'0,'0,'0, 0,0,1,'0,'0,'0, 0, "R9 still empty");
    step(0,1,0,4'hF,3,pat(base+66), 0,1,0,4'hF,3,pat(base+67), 0, "R10 disabled writes");
    step(1,0,0,'0,3,'0, 0,0,0,'0,3,'0, 0, "R10 no change");
    step(1,1,0,4'hF,10,pat(base+68), 0,0,0,'0,10,'0, 0, "R10 no clash when disabled");
    step(1,0,0,'0,10,'0, 1,1,0,4'hC,10,pat(base+69), 0, "R7 re-armed capture");
    step(1,1,0,4'hF,11,pat(base+70), 1,1,0,4'hF,11,pat(base+71), 0, "R7 second clash");
    step(0,0,1,'0,'0,'0, 1,0,0,'0,10,'0, 0, "R7 R8 holds 10");
    step(0,0,0,'0,'0,'0, 1,0,0,'0,11,'0, 0, "R4 left data kept");
    idle(4);
    check_val(q_lt.size() == 0 && q_rt.size() == 0, "R2", "pending results",
              DW'(q_lt.size() + q_rt.size()), '0);
  endtask

  initial begin
    run_mode(1'b0);
    run_mode(1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule